// File: doc/BRIEF.md
# Exact Posit Neuron Accumulator

This block computes one neuron's output in low-precision posit arithmetic. A start strobe loads a bias and latches whether a rectifier is applied. After that, weight/activation pairs arrive one per valid cycle. Every pair is decoded and multiplied exactly. The product is placed into a wide two's-complement fixed-point register whose least significant bit is the smallest possible product step, so no partial sum is ever rounded.

When the pair carrying the last flag has been absorbed, the block converts the register to an N-bit posit once. The conversion uses round-to-nearest-even and clamps at both ends of the range. A single-cycle valid strobe then presents the result. Hidden layers set the rectifier enable. An output layer leaves it clear and receives the rounded sum unchanged.

Top module: `posit_mac`

## Requirements
- R1: After a start and a sequence of accepted pairs, the result equals the exact value of bias plus the sum of weight times activation, rounded once to the nearest N-bit posit.
- R2: Operands are N-bit posits with ES exponent bits. All zeros is zero and 1 followed by zeros is NaR. A set top bit means negative, and the magnitude is the two's complement. The magnitude is decoded as a regime run ended by an opposite bit, then up to ES exponent bits, then fraction bits with a hidden one. Any non-NaR code presented as bias 0 times 1.0 (code 0x40 for N=8, ES=0) returns the same code.
- R3: When the exact sum lies exactly halfway between two neighbouring posits, the result is the one whose code has bit 0 clear.
- R4: A non-zero sum never yields zero or NaR. Magnitudes at or above maxpos (code 0111..1) give signed maxpos. Magnitudes at or below minpos (code 000..01) give signed minpos.
- R5: An exact sum of zero gives code zero.
- R6: If the bias or any accepted operand is NaR, the result is NaR (1000..0), whether or not the rectifier is enabled.
- R7: The rectifier enable is sampled with start. When it is set, a negative rounded result is replaced by zero. When it is clear, the result is passed unchanged. The level of the enable at other times has no effect.
- R8: After reset, result valid is low and the result is zero. Result valid is high for exactly one cycle, the second cycle after the cycle in which the last-marked pair is accepted.
- R9: Pair inputs are ignored while valid is low, and while the unit is idle, even when the last flag is set. They neither change the sum nor produce a result.
- R10: A start that arrives during accumulation discards the pending sum and begins a new neuron with the new bias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a neuron: load bias, sample rectifier enable |
| reluEn | input | 1 | Rectifier enable, sampled with start |
| bias | input | N | Bias posit |
| inValid | input | 1 | Weight/activation pair valid |
| inLast | input | 1 | Marks the final pair of the neuron |
| weight | input | N | Weight posit |
| act | input | N | Activation posit |
| outValid | output | 1 | One-cycle result strobe |
| result | output | N | Rounded posit result |

## Verification
The bench builds the unit with N=8, ES=0 and up to 64 pairs. At this size every one of the 256 codes can pass through the decoder and encoder in turn. The full-width accumulator also fits in a 64-bit integer, so the reference sum is exact. Runs of 64 maxpos products drive the guard bits and the saturation path. Single minpos products reach the lowest accumulator bits. Bias values next to 1.0, each combined with a minpos product, place the sum exactly on a rounding tie.

// File: rtl/posit_mac_pkg.sv
package posit_mac_pkg;

  // Width of the signed scale carried from the decoders
  localparam int SCW = 16;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCUM  = 2'd1,
    ST_FINISH = 2'd2
  } macState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadBias;
    logic addTerm;
    logic round;
  } macStrobes_t;

endpackage

// File: rtl/pmac_decode.sv
module pmac_decode #(
  parameter int N   = 8,
  parameter int ES  = 0,
  parameter int SCW = 16
) (
  input  logic [N-1:0]          code,
  output logic                  isZero,
  output logic                  isNaR,
  output logic                  sign,
  output logic signed [SCW-1:0] scale,
  output logic [N-3-ES:0]       sig
);

  logic [N-1:0] mag;
  logic [N-2:0] body;
  logic [N-2:0] rest;
  logic         runBit;
  int           runLen;
  int           regimeK;
  int           expoV;
  logic         stopRun;

  assign isZero = (code == '0);
  assign isNaR  = (code == {1'b1, {(N-1){1'b0}}});
  assign sign   = code[N-1];

  always_comb begin
    mag     = code[N-1] ? (~code + 1'b1) : code;
    body    = mag[N-2:0];
    runBit  = body[N-2];
    runLen  = 0;
    stopRun = 1'b0;
    for (int i = N - 2; i >= 0; i--) begin
      if (!stopRun) begin
        if (body[i] == runBit) runLen = runLen + 1;
        else stopRun = 1'b1;
      end
    end
    regimeK = runBit ? (runLen - 1) : -runLen;
    rest    = body << (runLen + 1);
  end

  if (ES > 0) begin : g_expo
    assign expoV = int'(rest[N-2 -: ES]);
  end else begin : g_noexpo
    assign expoV = 0;
  end

  always_comb begin
    scale = SCW'(regimeK * (2 ** ES) + expoV);
    sig   = {1'b1, rest[N-2-ES:2]};
  end

endmodule

// File: rtl/pmac_encode.sv
module pmac_encode #(
  parameter int N    = 8,
  parameter int ES   = 0,
  parameter int ACCW = 44,
  parameter int MAXS = 6,
  parameter int LSBE = -22
) (
  input  logic signed [ACCW-1:0] acc,
  output logic [N-1:0]           code
);

  localparam int ZW = N - 1 + ES + ACCW;

  logic            neg;
  logic [ACCW-1:0] mag;
  logic [ACCW-1:0] mant;
  logic [N-2:0]    regBits;
  logic [N-2:0]    kept;
  logic [N-2:0]    body;
  logic [ZW-1:0]   zv;
  logic            guardBit;
  logic            stickyBit;
  int              lead;
  int              sc;
  int              regK;
  int              expo;
  int              regLen;

  always_comb begin
    neg  = acc[ACCW-1];
    mag  = neg ? ACCW'(-acc) : ACCW'(acc);
    lead = 0;
    for (int i = 0; i < ACCW; i++) begin
      if (mag[i]) lead = i;
    end
    sc        = lead + LSBE;
    regK      = sc >>> ES;
    expo      = sc - (regK * (2 ** ES));
    regBits   = '0;
    regLen    = 0;
    mant      = '0;
    zv        = '0;
    kept      = '0;
    guardBit  = 1'b0;
    stickyBit = 1'b0;
    body      = '0;
    if (mag == '0) begin
      body = '0;
    end else if (sc >= MAXS) begin
      body = '1;
    end else if (sc < -MAXS) begin
      body = (N-1)'(1);
    end else begin
      if (regK >= 0) begin
        regBits = ~({(N-1){1'b1}} << (regK + 1));
        regBits = regBits << 1;
        regLen  = regK + 2;
      end else begin
        regBits = (N-1)'(1);
        regLen  = 1 - regK;
      end
      mant = mag << (ACCW - lead);
      zv   = (ZW'(regBits) << (ES + ACCW)) | (ZW'(expo) << ACCW) | ZW'(mant);
      zv   = zv << (N - 1 - regLen);
      kept      = zv[ZW-1 -: N-1];
      guardBit  = zv[ZW-N];
      stickyBit = |zv[ZW-N-1:0];
      if (guardBit && (stickyBit || kept[0])) kept = kept + 1'b1;
      body = kept;
    end
    code = neg ? (~{1'b0, body} + 1'b1) : {1'b0, body};
  end

endmodule

// File: rtl/pmac_datapath.sv
module pmac_datapath
  import posit_mac_pkg::*;
#(
  parameter int N        = 8,
  parameter int ES       = 0,
  parameter int MAXTERMS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  macStrobes_t strobes,
  input  logic        reluEn,
  input  logic [N-1:0] bias,
  input  logic [N-1:0] weight,
  input  logic [N-1:0] act,
  output logic [N-1:0] result
);

  localparam int FW    = N - 3 - ES;
  localparam int MAXS  = (N - 2) * (2 ** ES);
  localparam int GUARD = $clog2(MAXTERMS + 1);
  localparam int PW    = 2 * FW + 2;
  localparam int ACCW  = 4 * MAXS + PW + GUARD + 1;
  localparam int LSBE  = -(2 * MAXS + 2 * FW);
  localparam int NOPS  = 3;
  localparam logic [N-1:0] NAR = {1'b1, {(N-1){1'b0}}};

  // Operand order: 0 weight, 1 activation, 2 bias
  logic [N-1:0]          opCode [NOPS];
  logic                  opZero [NOPS];
  logic                  opNaR  [NOPS];
  logic                  opSign [NOPS];
  logic signed [SCW-1:0] opScale[NOPS];
  logic [FW:0]           opSig  [NOPS];

  assign opCode[0] = weight;
  assign opCode[1] = act;
  assign opCode[2] = bias;

  for (genvar g = 0; g < NOPS; g++) begin : g_dec
    pmac_decode #(.N(N), .ES(ES), .SCW(SCW)) u_dec (
      .code  (opCode[g]),
      .isZero(opZero[g]),
      .isNaR (opNaR[g]),
      .sign  (opSign[g]),
      .scale (opScale[g]),
      .sig   (opSig[g])
    );
  end

  logic [PW-1:0]          prodSig;
  logic [ACCW-1:0]        prodTerm;
  logic [ACCW-1:0]        biasTerm;
  logic                   prodNeg;
  logic                   prodNull;
  logic                   pairNaR;
  int                     prodShift;
  int                     biasShift;
  logic signed [ACCW-1:0] acc;
  logic                   narFlag;
  logic                   reluFlag;
  logic [N-1:0]           encCode;
  logic [N-1:0]           resultReg;

  always_comb begin
    prodSig   = PW'(opSig[0]) * PW'(opSig[1]);
    prodShift = int'(opScale[0]) + int'(opScale[1]) + 2 * MAXS;
    biasShift = int'(opScale[2]) + FW + 2 * MAXS;
    prodTerm  = ACCW'(prodSig) << prodShift;
    biasTerm  = ACCW'(opSig[2]) << biasShift;
    prodNeg   = opSign[0] ^ opSign[1];
    pairNaR   = opNaR[0] | opNaR[1];
    prodNull  = opZero[0] | opZero[1] | pairNaR;
  end

  pmac_encode #(.N(N), .ES(ES), .ACCW(ACCW), .MAXS(MAXS), .LSBE(LSBE)) u_enc (
    .acc (acc),
    .code(encCode)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      narFlag   <= 1'b0;
      reluFlag  <= 1'b0;
      resultReg <= '0;
    end else begin
      if (strobes.round) begin
        if (narFlag) resultReg <= NAR;
        else if (reluFlag && acc[ACCW-1]) resultReg <= '0;
        else resultReg <= encCode;
      end
      if (strobes.loadBias) begin
        narFlag  <= opNaR[2];
        reluFlag <= reluEn;
        if (opZero[2] || opNaR[2]) acc <= '0;
        else if (opSign[2]) acc <= -$signed(biasTerm);
        else acc <= $signed(biasTerm);
      end else if (strobes.addTerm) begin
        narFlag <= narFlag | pairNaR;
        if (!prodNull) begin
          if (prodNeg) acc <= acc - $signed(prodTerm);
          else acc <= acc + $signed(prodTerm);
        end
      end
    end
  end

  assign result = resultReg;

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadBias && !strobes.addTerm) |=> $stable(acc)); // R9

  AST_NAR_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.round && narFlag) |=> (resultReg == NAR)); // R6

  AST_NO_NAR_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.round && !narFlag) |=> (resultReg != NAR)); // R4

  AST_NO_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.round && !narFlag && acc != '0 && !(reluFlag && acc[ACCW-1]))
      |=> (resultReg != '0)); // R4

  AST_RELU_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.round && reluFlag && !narFlag) |=> !resultReg[N-1]); // R7

endmodule

// File: rtl/pmac_ctrl.sv
module pmac_ctrl
  import posit_mac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        inValid,
  input  logic        inLast,
  output macStrobes_t strobes,
  output logic        outValid
);

  macState_t state;
  macState_t stateNext;

  always_comb begin
    strobes.loadBias = start;
    strobes.addTerm  = (state == ST_ACCUM) && inValid && !start;
    strobes.round    = (state == ST_FINISH);
    stateNext        = state;
    if (start) begin
      stateNext = ST_ACCUM;
    end else begin
      case (state)
        ST_ACCUM:  if (inValid && inLast) stateNext = ST_FINISH;
        ST_FINISH: stateNext = ST_IDLE;
        default:   stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      outValid <= 1'b0;
    end else begin
      state    <= stateNext;
      outValid <= strobes.round;
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACCUM && inValid && inLast && !start) |-> ##2 outValid); // R8

  AST_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !start) |=> (state == ST_IDLE)); // R9

endmodule

// File: rtl/posit_mac.sv
module posit_mac
  import posit_mac_pkg::*;
#(
  parameter int N        = 8,
  parameter int ES       = 0,
  parameter int MAXTERMS = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         reluEn,
  input  logic [N-1:0] bias,
  input  logic         inValid,
  input  logic         inLast,
  input  logic [N-1:0] weight,
  input  logic [N-1:0] act,
  output logic         outValid,
  output logic [N-1:0] result
);

  macStrobes_t strobes;

  pmac_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .inValid (inValid),
    .inLast  (inLast),
    .strobes (strobes),
    .outValid(outValid)
  );

  pmac_datapath #(.N(N), .ES(ES), .MAXTERMS(MAXTERMS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .reluEn (reluEn),
    .bias   (bias),
    .weight (weight),
    .act    (act),
    .result (result)
  );

endmodule

// File: tb/sim_posit_mac.sv
module sim_posit_mac;

  localparam int N        = 8;
  localparam int ES       = 0;
  localparam int MAXTERMS = 64;
  localparam int HALF     = 11;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       reluEn = 1'b0;
  logic       inValid = 1'b0;
  logic       inLast = 1'b0;
  logic [7:0] bias = '0;
  logic [7:0] weight = '0;
  logic [7:0] act = '0;
  logic       outValid;
  logic [7:0] result;

  always #5 clk = ~clk;

  posit_mac #(.N(N), .ES(ES), .MAXTERMS(MAXTERMS)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .reluEn(reluEn), .bias(bias),
    .inValid(inValid), .inLast(inLast), .weight(weight), .act(act),
    .outValid(outValid), .result(result)
  );

  int  vecCount = 0;
  int  missCount = 0;
  bit  finished = 1'b0;
  logic [7:0] wArr [0:MAXTERMS-1];
  logic [7:0] aArr [0:MAXTERMS-1];

  // Value of an 8-bit, es=0 posit in units of 2^-11
  function automatic longint unitsOf(input logic [7:0] x);
    logic [7:0] m;
    int idx, run, k, fbits;
    logic r0;
    longint fr, v;
    if (x == 8'h00) return 0;
    m = x[7] ? (~x + 8'd1) : x;
    r0 = m[6];
    idx = 6;
    run = 0;
    while (idx >= 0 && m[idx] == r0) begin
      run++;
      idx--;
    end
    k = r0 ? run - 1 : -run;
    idx--;
    fbits = (idx >= 0) ? idx + 1 : 0;
    fr = longint'(m) & ((longint'(1) << fbits) - 1);
    v = ((longint'(1) << fbits) + fr) <<< (k + HALF - fbits);
    return x[7] ? -v : v;
  endfunction

  function automatic longint posVal(input int q);
    return unitsOf(8'(q)) <<< HALF;
  endfunction

  // Nearest posit to s (units 2^-22), ties to even code, clamped
  function automatic logic [7:0] roundPosit(input longint s);
    longint m, d1, d2;
    int p;
    if (s == 0) return 8'h00;
    m = (s < 0) ? -s : s;
    p = 1;
    if (m >= posVal(127)) p = 127;
    else if (m <= posVal(1)) p = 1;
    else begin
      for (int q = 1; q < 127; q++) begin
        if (m >= posVal(q) && m < posVal(q + 1)) begin
          d1 = m - posVal(q);
          d2 = posVal(q + 1) - m;
          if (d1 < d2) p = q;
          else if (d2 < d1) p = q + 1;
          else p = (q % 2 == 0) ? q : q + 1;
        end
      end
    end
    return (s < 0) ? 8'(-p) : 8'(p);
  endfunction

  task automatic chk(input bit ok, input string req, input int actV, input int expV);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s: actual %0h expected %0h", req, actV, expV);
    end
  endtask

  task automatic runNeuron(input logic [7:0] b, input int n, input bit relu,
                           input bit gaps, input string req);
    longint sum;
    bit nar;
    logic [7:0] expV;
    nar = (b == 8'h80);
    sum = nar ? 0 : (unitsOf(b) <<< HALF);
    for (int i = 0; i < n; i++) begin
      if (wArr[i] == 8'h80 || aArr[i] == 8'h80) nar = 1'b1;
      else sum += unitsOf(wArr[i]) * unitsOf(aArr[i]);
    end
    expV = nar ? 8'h80 : roundPosit(sum);
    if (!nar && relu && expV[7]) expV = 8'h00;
    @(negedge clk);
    start = 1'b1; bias = b; reluEn = relu; inValid = 1'b0; inLast = 1'b0;
    @(negedge clk);
    start = 1'b0; bias = 8'($urandom); reluEn = 1'($urandom);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin
        inValid = 1'b0; inLast = 1'b1;
        weight = 8'h7F; act = 8'h7F;
        @(negedge clk);
      end
      inValid = 1'b1; weight = wArr[i]; act = aArr[i]; inLast = (i == n - 1);
      @(negedge clk);
    end
    inValid = 1'b0; inLast = 1'b0;
    chk(outValid == 1'b0, "R8 early", int'(outValid), 0);
    @(negedge clk);
    chk(outValid == 1'b1, "R8 strobe", int'(outValid), 1);
    chk(result == expV, req, int'(result), int'(expV));
    @(negedge clk);
    chk(outValid == 1'b0, "R8 width", int'(outValid), 0);
  endtask

  function automatic logic [7:0] randOperand();
    logic [7:0] v;
    if ($urandom % 2 == 0) v = 8'($urandom);
    else v = {1'($urandom), 2'b01, 5'($urandom)};
    if (v == 8'h80) v = 8'h40;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R8 reset valid", int'(outValid), 0);
    chk(result == 8'h00, "R8 reset result", int'(result), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R9: pairs while idle produce nothing
    for (int i = 0; i < 3; i++) begin
      inValid = 1'b1; inLast = 1'b1; weight = 8'h7F; act = 8'h7F;
      @(negedge clk);
      chk(outValid == 1'b0, "R9 idle", int'(outValid), 0);
    end
    inValid = 1'b0; inLast = 1'b0;

    // R2: every code round-trips as 0 + x * 1.0
    for (int c = 0; c < 256; c++) begin
      wArr[0] = 8'(c); aArr[0] = 8'h40;
      runNeuron(8'h00, 1, 1'b0, 1'b0, (c == 128) ? "R6 decode" : "R2 decode");
    end

    // R5: exact cancellation
    wArr[0] = 8'h40; aArr[0] = 8'hC0;
    runNeuron(8'h40, 1, 1'b0, 1'b0, "R5 zero");

    // R3: ties
    wArr[0] = 8'h01; aArr[0] = 8'h40;
    runNeuron(8'h40, 1, 1'b0, 1'b0, "R3 tie down");
    runNeuron(8'h41, 1, 1'b0, 1'b0, "R3 tie up");
    chk(result == 8'h42, "R3 tie up code", int'(result), 8'h42);

    // R4: saturation and flush protection
    for (int i = 0; i < MAXTERMS; i++) begin wArr[i] = 8'h7F; aArr[i] = 8'h7F; end
    runNeuron(8'h7F, MAXTERMS, 1'b0, 1'b0, "R4 maxpos");
    for (int i = 0; i < MAXTERMS; i++) begin wArr[i] = 8'h81; aArr[i] = 8'h7F; end
    runNeuron(8'h81, MAXTERMS, 1'b0, 1'b0, "R4 neg maxpos");
    wArr[0] = 8'h01; aArr[0] = 8'h01;
    runNeuron(8'h00, 1, 1'b0, 1'b0, "R4 minpos");
    wArr[0] = 8'hFF; aArr[0] = 8'h01;
    runNeuron(8'h00, 1, 1'b0, 1'b0, "R4 neg minpos");

    // R6: NaR propagation
    wArr[0] = 8'h40; aArr[0] = 8'h40; wArr[1] = 8'h30; aArr[1] = 8'h80;
    runNeuron(8'h40, 2, 1'b0, 1'b0, "R6 operand");
    runNeuron(8'h40, 2, 1'b1, 1'b0, "R6 with relu");
    wArr[0] = 8'h40; aArr[0] = 8'h40;
    runNeuron(8'h80, 1, 1'b0, 1'b0, "R6 bias");

    // R7: rectifier
    wArr[0] = 8'h40; aArr[0] = 8'hC0;
    runNeuron(8'h00, 1, 1'b1, 1'b0, "R7 relu on");
    runNeuron(8'h00, 1, 1'b0, 1'b0, "R7 relu off");
    wArr[0] = 8'h50; aArr[0] = 8'h48;
    runNeuron(8'h00, 1, 1'b1, 1'b0, "R7 relu positive");

    // R9: gaps with last flag high are ignored
    for (int i = 0; i < 8; i++) begin wArr[i] = randOperand(); aArr[i] = randOperand(); end
    runNeuron(8'h38, 8, 1'b0, 1'b1, "R9 gaps");

    // R10: restart mid-accumulation
    @(negedge clk);
    start = 1'b1; bias = 8'h7F; reluEn = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2; i++) begin
      inValid = 1'b1; inLast = 1'b0; weight = 8'h7F; act = 8'h7F;
      @(negedge clk);
    end
    inValid = 1'b0;
    wArr[0] = 8'h40; aArr[0] = 8'h40;
    runNeuron(8'h40, 1, 1'b0, 1'b0, "R10 restart");

    // R1: random neurons against the exact model
    for (int t = 0; t < 150; t++) begin
      int n;
      n = 1 + int'($urandom % MAXTERMS);
      for (int i = 0; i < n; i++) begin wArr[i] = randOperand(); aArr[i] = randOperand(); end
      runNeuron(randOperand(), n, 1'($urandom), 1'($urandom), "R1 random");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule